// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block converts a virtual address into a physical address by reading translation descriptors out of memory. A client presents a virtual address together with the base of the first-level table. The walker then reads one first-level descriptor over a plain request/response memory port and decodes its type. A section entry maps a whole 1MB region and ends the walk after that single read. A coarse entry points at a 256-entry second-level table, one entry per 4KB page, and the walker makes a second, dependent read into that table.

When the walk ends, the block raises a one-cycle done pulse. In that cycle it presents the physical address, the two access permission bits, the 4-bit domain number, the cacheable and bufferable flags, and a fault indication that says at which level the walk failed. The block handles one walk at a time. It does not cache translations and does not check permissions or domains: it only finds and decodes the entries.

Top module: `pt_walker`

## Requirements
- R1: While reset is low and in the first cycle after it, busy, done and mem_req are 0, and every result output is 0.
- R2: The cycle after a request is accepted, mem_req is high for exactly one cycle. In that cycle mem_addr is {ttb[31:14], va[31:20], 2'b00}.
- R3: If the first-level word has bits [1:0] = 2'b10 (section), done follows without a second read. The results are: pa = {desc[31:20], va[19:0]}, ap = desc[11:10], domain = desc[8:5], cacheable = desc[3], bufferable = desc[2], fault = 0.
- R4: If the first-level word has bits [1:0] = 2'b01 (coarse), mem_req pulses once more, with mem_addr = {desc[31:10], va[19:12], 2'b00}.
- R5: If the second-level word has bits [1:0] = 2'b10 (small page), the results are: pa = {entry[31:12], va[11:0]}, ap = entry[5:4], cacheable = entry[3], bufferable = entry[2]. The domain comes from bits [8:5] of the first-level word, and fault = 0.
- R6: A first-level word with bits [1:0] = 2'b00 or 2'b11 ends the walk after one read. It sets fault = 1 and fault_l2 = 0, and pa, ap, domain, cacheable and bufferable are all 0.
- R7: A second-level word with any bits [1:0] other than 2'b10 ends the walk with fault = 1 and fault_l2 = 1, and all other result fields 0.
- R8: busy rises the cycle after acceptance and stays high through the single-cycle done pulse. It falls the cycle after done. A req_valid seen while busy is ignored.
- R9: Each decode waits for mem_rvalid, however long that takes. mem_rdata is ignored without mem_rvalid, and a mem_rvalid outside a wait changes nothing.
- R10: The result outputs change only on the cycle done is high. They hold their value until the next walk finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request; taken when busy is low |
| req_va | input | 32 | Virtual address to translate |
| req_ttb | input | 32 | First-level table base (bits 31:14 used) |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | One-cycle descriptor read strobe |
| mem_addr | output | 32 | Descriptor read address, valid with mem_req |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Descriptor word returned by memory |
| done | output | 1 | One-cycle pulse; result outputs valid |
| res_pa | output | 32 | Physical address |
| res_ap | output | 2 | Access permission bits |
| res_domain | output | 4 | Domain number |
| res_cache | output | 1 | Cacheable flag |
| res_buf | output | 1 | Bufferable flag |
| res_fault | output | 1 | Walk ended in a fault |
| res_fault_l2 | output | 1 | The fault came from the second-level entry |

## Verification
The bench builds the walker with its default parameters: a 32-bit address, a 20-bit section offset and a 12-bit page offset. These give a 12-bit first-level index and an 8-bit second-level index, so the fetch addresses and both address splices can be checked bit for bit. Random walks cover all four first-level types and all four second-level types, with random read latencies and junk data on the bus while valid is low. Directed walks cover all-ones addresses, long latencies, stray read responses while idle, and requests made while a walk is running.

// File: rtl/pt_walker_pkg.sv
// Package: shared types and descriptor encodings for the table walker.
// Assumes descriptor type codes sit in bits [1:0] of every table word.
package pt_walker_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_DONE
    } walk_state_t;

    // Attributes reported with a translation.
    typedef struct packed {
        logic [1:0] ap;
        logic [3:0] domain;
        logic       cache;
        logic       buff;
    } walk_attr_t;

    localparam logic [1:0] L1_TYPE_COARSE  = 2'b01;
    localparam logic [1:0] L1_TYPE_SECTION = 2'b10;
    localparam logic [1:0] L2_TYPE_SMALL   = 2'b10;

endpackage

// File: rtl/ptw_addr_gen.sv
// Module: forms the descriptor read address for either walk level.
// Assumes the first-level table is indexed by the section number and the
// second-level table by the page number within the section, word aligned.
module ptw_addr_gen #(
    parameter int AW         = 32,
    parameter int SEC_OFF_W  = 20,
    parameter int PAGE_OFF_W = 12
) (
    input  logic [SEC_OFF_W-3:0]                     ttb_hi,
    input  logic [AW-SEC_OFF_W-1:0]                  l1_idx,
    input  logic [AW-SEC_OFF_W+PAGE_OFF_W-3:0]       cbase,
    input  logic [SEC_OFF_W-PAGE_OFF_W-1:0]          l2_idx,
    input  logic                                     sel_l2,
    output logic [AW-1:0]                            addr
);
    logic [AW-1:0] l1_addr;
    logic [AW-1:0] l2_addr;

    // Splice base, index and word offset for each level.
    always_comb begin
        l1_addr = {ttb_hi, l1_idx, 2'b00};
        l2_addr = {cbase, l2_idx, 2'b00};
    end

    // Pick the level the walker is currently fetching.
    always_comb begin
        addr = sel_l2 ? l2_addr : l1_addr;
    end
endmodule

// File: rtl/ptw_l1_decode.sv
// Module: decodes a first-level descriptor into type flags, section
// translation, attributes and the coarse table base.
// Assumes type in [1:0], C/B in [3:2], domain in [8:5], AP in [11:10].
module ptw_l1_decode
    import pt_walker_pkg::*;
#(
    parameter int AW         = 32,
    parameter int SEC_OFF_W  = 20,
    parameter int PAGE_OFF_W = 12
) (
    input  logic [AW-1:0]                        desc,
    input  logic [SEC_OFF_W-1:0]                 sec_off,
    output logic                                 is_section,
    output logic                                 is_coarse,
    output logic [AW-1:0]                        sec_pa,
    output walk_attr_t                           attr,
    output logic [AW-SEC_OFF_W+PAGE_OFF_W-3:0]   cbase
);
    localparam int CB_LSB = SEC_OFF_W - PAGE_OFF_W + 2;

    wire unused_l1_bits = desc[9] ^ desc[4];

    // Classify the descriptor by its type field.
    always_comb begin
        is_section = (desc[1:0] == L1_TYPE_SECTION);
        is_coarse  = (desc[1:0] == L1_TYPE_COARSE);
    end

    // Build section address, attributes and coarse table base.
    always_comb begin
        sec_pa      = {desc[AW-1:SEC_OFF_W], sec_off};
        attr.ap     = desc[11:10];
        attr.domain = desc[8:5];
        attr.cache  = desc[3];
        attr.buff   = desc[2];
        cbase       = desc[AW-1:CB_LSB];
    end
endmodule

// File: rtl/ptw_l2_decode.sv
// Module: decodes a second-level entry as a small page or a fault.
// Assumes small page type 2'b10, AP in [5:4], C/B in [3:2]; the domain is
// inherited from the first-level descriptor.
module ptw_l2_decode
    import pt_walker_pkg::*;
#(
    parameter int AW         = 32,
    parameter int PAGE_OFF_W = 12
) (
    input  logic [AW-1:0]         entry,
    input  logic [PAGE_OFF_W-1:0] page_off,
    input  logic [3:0]            domain,
    output logic                  is_page,
    output logic [AW-1:0]         pa,
    output walk_attr_t            attr
);
    wire unused_l2_bits = ^entry[PAGE_OFF_W-1:6];

    // Recognise the only supported second-level type.
    always_comb begin
        is_page = (entry[1:0] == L2_TYPE_SMALL);
    end

    // Form page address and attributes.
    always_comb begin
        pa          = {entry[AW-1:PAGE_OFF_W], page_off};
        attr.ap     = entry[5:4];
        attr.domain = domain;
        attr.cache  = entry[3];
        attr.buff   = entry[2];
    end
endmodule

// File: rtl/pt_walker.sv
// Module: two-level translation table walker, top level.
// Sequences one or two dependent descriptor reads per request, one walk at
// a time. Memory may answer any number of cycles after mem_req, but not in
// the same cycle. Results are registered and held until the next walk ends.
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int AW         = 32,
    parameter int SEC_OFF_W  = 20,
    parameter int PAGE_OFF_W = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_va,
    input  logic [AW-1:0] req_ttb,
    output logic          busy,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [AW-1:0] mem_rdata,
    output logic          done,
    output logic [AW-1:0] res_pa,
    output logic [1:0]    res_ap,
    output logic [3:0]    res_domain,
    output logic          res_cache,
    output logic          res_buf,
    output logic          res_fault,
    output logic          res_fault_l2
);
    localparam int L1_IDX_W    = AW - SEC_OFF_W;
    localparam int L2_IDX_W    = SEC_OFF_W - PAGE_OFF_W;
    localparam int L1_BASE_LSB = L1_IDX_W + 2;
    localparam int L2_BASE_LSB = L2_IDX_W + 2;
    localparam int TTB_W       = AW - L1_BASE_LSB;
    localparam int CB_W        = AW - L2_BASE_LSB;

    walk_state_t      state_q;
    logic [AW-1:0]    va_q;
    logic [TTB_W-1:0] ttb_q;
    logic [CB_W-1:0]  cbase_q;
    logic [3:0]       dom_q;

    logic [AW-1:0]    pa_q;
    walk_attr_t       attr_q;
    logic             fault_q;
    logic             fault_l2_q;

    logic             l1_section;
    logic             l1_coarse;
    logic [AW-1:0]    l1_pa;
    walk_attr_t       l1_attr;
    logic [CB_W-1:0]  l1_cbase;
    logic             l2_page;
    logic [AW-1:0]    l2_pa;
    walk_attr_t       l2_attr;

    wire unused_ttb_low = ^req_ttb[L1_BASE_LSB-1:0];

    ptw_addr_gen #(
        .AW         (AW),
        .SEC_OFF_W  (SEC_OFF_W),
        .PAGE_OFF_W (PAGE_OFF_W)
    ) u_addr (
        .ttb_hi (ttb_q),
        .l1_idx (va_q[AW-1:SEC_OFF_W]),
        .cbase  (cbase_q),
        .l2_idx (va_q[SEC_OFF_W-1:PAGE_OFF_W]),
        .sel_l2 (state_q == ST_L2_REQ),
        .addr   (mem_addr)
    );

    ptw_l1_decode #(
        .AW         (AW),
        .SEC_OFF_W  (SEC_OFF_W),
        .PAGE_OFF_W (PAGE_OFF_W)
    ) u_l1 (
        .desc       (mem_rdata),
        .sec_off    (va_q[SEC_OFF_W-1:0]),
        .is_section (l1_section),
        .is_coarse  (l1_coarse),
        .sec_pa     (l1_pa),
        .attr       (l1_attr),
        .cbase      (l1_cbase)
    );

    ptw_l2_decode #(
        .AW         (AW),
        .PAGE_OFF_W (PAGE_OFF_W)
    ) u_l2 (
        .entry    (mem_rdata),
        .page_off (va_q[PAGE_OFF_W-1:0]),
        .domain   (dom_q),
        .is_page  (l2_page),
        .pa       (l2_pa),
        .attr     (l2_attr)
    );

    // Walk sequencing, request capture and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            va_q       <= '0;
            ttb_q      <= '0;
            cbase_q    <= '0;
            dom_q      <= '0;
            pa_q       <= '0;
            attr_q     <= '0;
            fault_q    <= 1'b0;
            fault_l2_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q    <= req_va;
                        ttb_q   <= req_ttb[AW-1:L1_BASE_LSB];
                        state_q <= ST_L1_REQ;
                    end
                end
                ST_L1_REQ: state_q <= ST_L1_WAIT;
                ST_L1_WAIT: begin
                    if (mem_rvalid) begin
                        if (l1_section) begin
                            pa_q       <= l1_pa;
                            attr_q     <= l1_attr;
                            fault_q    <= 1'b0;
                            fault_l2_q <= 1'b0;
                            state_q    <= ST_DONE;
                        end else if (l1_coarse) begin
                            cbase_q <= l1_cbase;
                            dom_q   <= l1_attr.domain;
                            state_q <= ST_L2_REQ;
                        end else begin
                            pa_q       <= '0;
                            attr_q     <= '0;
                            fault_q    <= 1'b1;
                            fault_l2_q <= 1'b0;
                            state_q    <= ST_DONE;
                        end
                    end
                end
                ST_L2_REQ: state_q <= ST_L2_WAIT;
                ST_L2_WAIT: begin
                    if (mem_rvalid) begin
                        if (l2_page) begin
                            pa_q       <= l2_pa;
                            attr_q     <= l2_attr;
                            fault_q    <= 1'b0;
                            fault_l2_q <= 1'b0;
                        end else begin
                            pa_q       <= '0;
                            attr_q     <= '0;
                            fault_q    <= 1'b1;
                            fault_l2_q <= 1'b1;
                        end
                        state_q <= ST_DONE;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the handshake and result outputs from the walk state.
    always_comb begin
        busy         = (state_q != ST_IDLE);
        mem_req      = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
        done         = (state_q == ST_DONE);
        res_pa       = pa_q;
        res_ap       = attr_q.ap;
        res_domain   = attr_q.domain;
        res_cache    = attr_q.cache;
        res_buf      = attr_q.buff;
        res_fault    = fault_q;
        res_fault_l2 = fault_l2_q;
    end
endmodule

// File: rtl/pt_walker_chk.sv
// Module: protocol checker for pt_walker, attached by bind.
// Counts descriptor reads per walk to check how many fetches each outcome used.
module pt_walker_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          busy,
    input logic          mem_req,
    input logic          mem_rvalid,
    input logic          done,
    input logic [AW-1:0] res_pa,
    input logic          res_fault,
    input logic          res_fault_l2
);
    logic [1:0] fetch_cnt;

    // Count reads since the last accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_cnt <= 2'd0;
        end else if (req_valid && !busy) begin
            fetch_cnt <= 2'd0;
        end else if (mem_req && fetch_cnt != 2'd3) begin
            fetch_cnt <= fetch_cnt + 2'd1;
        end
    end

    a_r2_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    a_r2_req_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (busy && !done));
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    a_r8_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    a_r9_done_after_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_rvalid));
    a_r6_one_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_fault && !res_fault_l2) |-> (fetch_cnt == 2'd1));
    a_r6_fault_pa_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_fault) |-> (res_pa == '0));
    a_r7_two_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_fault_l2) |-> (fetch_cnt == 2'd2));
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(res_pa) && $stable(res_fault) && $stable(res_fault_l2)));
endmodule

bind pt_walker pt_walker_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .busy         (busy),
    .mem_req      (mem_req),
    .mem_rvalid   (mem_rvalid),
    .done         (done),
    .res_pa       (res_pa),
    .res_fault    (res_fault),
    .res_fault_l2 (res_fault_l2)
);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic [31:0] req_ttb = '0;
    logic        busy;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic [31:0] res_pa;
    logic [1:0]  res_ap;
    logic [3:0]  res_domain;
    logic        res_cache;
    logic        res_buf;
    logic        res_fault;
    logic        res_fault_l2;

    int total = 0;
    int failed = 0;

    always #5 clk = ~clk;

    pt_walker u_pt_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_ttb(req_ttb), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done),
        .res_pa(res_pa), .res_ap(res_ap), .res_domain(res_domain),
        .res_cache(res_cache), .res_buf(res_buf), .res_fault(res_fault),
        .res_fault_l2(res_fault_l2)
    );

    function automatic logic [41:0] pack_out();
        return {res_pa, res_ap, res_domain, res_cache, res_buf, res_fault, res_fault_l2};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] l1_addr(input logic [31:0] va, input logic [31:0] ttb);
        return {ttb[31:14], va[31:20], 2'b00};
    endfunction

    function automatic logic [31:0] l2_addr(input logic [31:0] va, input logic [31:0] d1);
        return {d1[31:10], va[19:12], 2'b00};
    endfunction

    // Expected {pa, ap, domain, c, b, fault, fault_l2} from the requirements.
    function automatic logic [41:0] expect_res(input logic [31:0] va, input logic [31:0] d1,
                                               input logic [31:0] d2);
        if (d1[1:0] == 2'b10)
            return {d1[31:20], va[19:0], d1[11:10], d1[8:5], d1[3], d1[2], 2'b00};
        if (d1[1:0] == 2'b01) begin
            if (d2[1:0] == 2'b10)
                return {d2[31:12], va[11:0], d2[5:4], d1[8:5], d2[3], d2[2], 2'b00};
            return {40'd0, 2'b11};
        end
        return {40'd0, 2'b10};
    endfunction

    // One complete walk with the bench acting as memory.
    task automatic walk(input logic [31:0] va, input logic [31:0] ttb, input logic [31:0] d1,
                        input logic [31:0] d2, input int lat1, input int lat2, input bit poke);
        logic [41:0] exp_r;
        logic [41:0] held;
        exp_r = expect_res(va, d1, d2);
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_ttb = ttb;
        @(negedge clk);
        req_valid = 1'b0; req_va = $urandom; req_ttb = $urandom;
        check(busy == 1'b1, "R8 busy after accept", {63'd0, busy}, 64'd1);
        check(mem_req == 1'b1 && mem_addr == l1_addr(va, ttb), "R2 level-one fetch",
              {31'd0, mem_req, mem_addr}, {31'd0, 1'b1, l1_addr(va, ttb)});
        for (int i = 0; i < lat1; i++) begin
            @(negedge clk);
            mem_rdata = $urandom;
            if (poke) begin req_valid = 1'b1; req_va = $urandom; req_ttb = $urandom; end
        end
        req_valid = 1'b0;
        mem_rvalid = 1'b1; mem_rdata = d1;
        @(negedge clk);
        mem_rvalid = 1'b0; mem_rdata = $urandom;
        if (d1[1:0] == 2'b01) begin
            check(mem_req == 1'b1 && mem_addr == l2_addr(va, d1), "R4 level-two fetch",
                  {31'd0, mem_req, mem_addr}, {31'd0, 1'b1, l2_addr(va, d1)});
            for (int i = 0; i < lat2; i++) begin
                @(negedge clk);
                mem_rdata = $urandom;
                if (poke) begin req_valid = 1'b1; req_va = $urandom; end
            end
            req_valid = 1'b0;
            mem_rvalid = 1'b1; mem_rdata = d2;
            @(negedge clk);
            mem_rvalid = 1'b0; mem_rdata = $urandom;
        end else begin
            check(mem_req == 1'b0, "R3/R6 no second fetch", {63'd0, mem_req}, 64'd0);
        end
        check(done == 1'b1, "R8 done pulse", {63'd0, done}, 64'd1);
        if (d1[1:0] == 2'b10)
            check(pack_out() == exp_r, "R3 section result", {22'd0, pack_out()}, {22'd0, exp_r});
        else if (d1[1:0] != 2'b01)
            check(pack_out() == exp_r, "R6 level-one fault", {22'd0, pack_out()}, {22'd0, exp_r});
        else if (d2[1:0] == 2'b10)
            check(pack_out() == exp_r, "R5 small page result", {22'd0, pack_out()}, {22'd0, exp_r});
        else
            check(pack_out() == exp_r, "R7 level-two fault", {22'd0, pack_out()}, {22'd0, exp_r});
        held = pack_out();
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0 && mem_req == 1'b0, "R8 walk ends",
              {61'd0, done, busy, mem_req}, 64'd0);
        check(pack_out() == held, "R10 result held", {22'd0, pack_out()}, {22'd0, held});
    endtask

    function automatic logic [31:0] rand_l1(input logic [1:0] t);
        logic [31:0] w;
        w = $urandom;
        return {w[31:2], t};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        total++; failed++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        logic [41:0] held;
        void'($urandom(32'h1234_5eed));
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && mem_req == 1'b0, "R1 outputs in reset",
              {61'd0, busy, done, mem_req}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && mem_req == 1'b0 && pack_out() == '0,
              "R1 after reset", {22'd0, pack_out()}, 64'd0);

        // R9: stray response while idle does nothing.
        mem_rvalid = 1'b1; mem_rdata = 32'hFFFF_FC12;
        @(negedge clk); @(negedge clk);
        check(done == 1'b0 && busy == 1'b0 && pack_out() == '0, "R9 stray rvalid ignored",
              {22'd0, pack_out()}, 64'd0);
        mem_rvalid = 1'b0;

        walk(32'h1234_5678, 32'hABCD_4000, 32'h8760_0D6E, 32'h0, 1, 1, 1'b0);
        walk(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'h0, 1, 1, 1'b0);
        walk(32'h0040_3ABC, 32'h0010_0000, 32'h5555_5431, 32'hCAFE_B03E, 2, 3, 1'b0);
        walk(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFD, 32'hFFFF_FFFE, 1, 1, 1'b0);
        walk(32'h7777_7777, 32'h2000_0000, 32'hFFFF_FFFC, 32'h0, 3, 1, 1'b0);
        walk(32'h7777_7777, 32'h2000_0000, 32'h0000_0003, 32'h0, 1, 1, 1'b1);
        walk(32'h0BAD_F00D, 32'h3000_0000, 32'h1234_5621, 32'hFFFF_FFFC, 2, 2, 1'b0);
        walk(32'h0BAD_F00D, 32'h3000_0000, 32'h1234_5621, 32'hFFFF_FFFD, 1, 1, 1'b0);
        walk(32'h0BAD_F00D, 32'h3000_0000, 32'h1234_5621, 32'hFFFF_FFFF, 1, 1, 1'b0);
        // R9: long latency with junk data, R8: requests poked while busy.
        walk(32'h89AB_CDEF, 32'h4444_C000, 32'h9999_9E61, 32'h1357_9BDA, 9, 12, 1'b1);

        for (int n = 0; n < 60; n++) begin
            logic [1:0]  t1;
            logic [31:0] d2w;
            t1  = 2'($urandom_range(0, 3));
            d2w = $urandom;
            walk($urandom, $urandom, rand_l1(t1), d2w,
                 $urandom_range(1, 5), $urandom_range(1, 5), 1'($urandom_range(0, 1)));
        end

        // R10: results hold across idle cycles with traffic on the inputs.
        held = pack_out();
        mem_rdata = $urandom;
        repeat (4) @(negedge clk);
        check(pack_out() == held && busy == 1'b0, "R10 idle hold",
              {22'd0, pack_out()}, {22'd0, held});

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule